// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands at a width of 8, 16 or 32 bits. It registers the result together with six status flags: carry, parity, auxiliary carry, zero, sign and overflow. The width is picked on every operation with a two-bit size select. Operand bits above the active width play no part in any result or flag. Subtraction takes a borrow-in through the same input that addition uses as carry-in. The carry flag then reports the borrow out of the top bit of the active width.

A logical mode reuses the same result and flag path for bitwise operations. In that mode carry and overflow are cleared and auxiliary carry keeps its previous value. Parity, zero and sign follow the logical result. An update enable qualifies every clock edge. When it is low, the result and all flags hold. The flags also appear packed into a 16-bit status word at fixed bit positions, so a neighbouring register can take them directly.

Top module: `asf_flag_gen`

## Requirements
- R1: Carry (`cf`) is set when an addition carries out of the top bit of the active width, or when a subtraction (`op_a - op_b - carry_in`) needs a borrow out of that bit. It is cleared otherwise.
- R2: Parity (`pf`) is set when bits 7..0 of the result hold an even number of ones, at every width and in both modes.
- R3: Auxiliary carry (`af`) in arithmetic mode is set on a carry out of bit 3 (add) or a borrow into bit 4 from the low nibble (subtract). It is cleared otherwise.
- R4: Zero (`zf`) is set exactly when every result bit within the active width is zero.
- R5: Sign (`sf`) equals the top bit of the result at the active width.
- R6: Overflow (`of`) in arithmetic mode is set when exactly one of two events occurs: a carry/borrow into the top bit of the active width, or a carry/borrow out of it.
- R7: When `logic_en` is 1, the result is `logic_fn` applied to the operands: 00 AND, 01 OR, 10 XOR, 11 passes `op_a`. In this mode `cf` and `of` are cleared, `af` keeps its previous value, and `pf`, `zf` and `sf` follow the result.
- R8: `status_word` carries `cf` at bit 0, `pf` at bit 2, `af` at bit 4, `zf` at bit 6, `sf` at bit 7 and `of` at bit 11. All its other bits are zero.
- R9: While `upd_en` is 0, `result`, every flag and `status_word` keep their values.
- R10: `size_sel` encodes 00 = 8-bit, 01 = 16-bit, 10 = 32-bit; 11 acts as 32-bit. Operand bits above the active width do not affect any output, and result bits above it read zero.
- R11: A synchronous active-high `rst` clears `result`, `cf`, `af`, `sf` and `of`, and sets `zf` and `pf`, which is consistent with a zero result.
- R12: An operation presented with `upd_en` high appears on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update enable for result and flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend) |
| carry_in | input | 1 | Carry-in for add, borrow-in for subtract |
| sub_sel | input | 1 | 1 selects subtract, 0 selects add |
| size_sel | input | 2 | Operand width select |
| logic_en | input | 1 | 1 selects logical mode |
| logic_fn | input | 2 | Logical function in logical mode |
| result | output | 32 | Registered result, zero above active width |
| cf | output | 1 | Carry / borrow flag |
| pf | output | 1 | Low-byte even parity flag |
| af | output | 1 | Nibble carry / borrow flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Signed overflow flag |
| status_word | output | 16 | Packed flags |

## Verification
The bench runs the 8-bit width through a near-exhaustive sweep: every value of `op_a` against every fifth value of `op_b`, with both carry-in values, for add and for subtract. This separates carry from overflow, and nibble borrow from full-width borrow, at every sign and nibble boundary. Junk is placed in the upper operand bits during the sweep, so any leak from bits above the active width is caught. The 16- and 32-bit widths, and the spare size code, get the sign-boundary corners (max positive plus one, zero minus one, all ones plus one) and a pseudo-random stream. The stream shows that flags are taken from the selected width and not from a fixed one. Logical mode is run with auxiliary carry first driven both ways, which shows it is held rather than cleared. Idle cycles with changing inputs show the hold behaviour.

// File: rtl/asf_pkg.sv
package asf_pkg;

  localparam int ASF_WORD_W = 16;
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_OF = 11;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_SPARE = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    LF_AND  = 2'b00,
    LF_OR   = 2'b01,
    LF_XOR  = 2'b10,
    LF_PASS = 2'b11
  } lfn_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } flags_t;

  // Spare size code folds onto the widest width.
  function automatic logic [1:0] size_idx(input logic [1:0] s);
    return (s == SZ_SPARE) ? 2'(SZ_WORD) : s;
  endfunction

endpackage

// File: rtl/asf_adder.sv
module asf_adder #(
  parameter int BW = 8,
  localparam int DW = 4 * BW,
  localparam int NIB = BW / 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] mask,
  input  logic [1:0]    idx,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cf_o,
  output logic          af_o,
  output logic          of_o
);
  logic [DW-1:0] am;
  logic [DW-1:0] bm;
  logic [DW:0]   full;
  logic          cx;
  logic [2:0]    co_top;
  logic [2:0]    ci_top;
  logic          c_nib;

  // Subtract is add of the inverted operand with inverted borrow.
  always_comb begin
    am   = a & mask;
    bm   = (sub ? ~b : b) & mask;
    cx   = cin ^ sub;
    full = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, cx};
    sum  = full[DW-1:0] & mask;
  end

  // One carry tap per supported width.
  for (genvar g = 0; g < 3; g++) begin : g_tap
    localparam int W = BW << g;
    assign co_top[g] = full[W];
    assign ci_top[g] = am[W-1] ^ bm[W-1] ^ full[W-1];
  end

  assign c_nib = am[NIB] ^ bm[NIB] ^ full[NIB];

  always_comb begin
    cf_o = co_top[idx] ^ sub;
    of_o = co_top[idx] ^ ci_top[idx];
    af_o = c_nib ^ sub;
  end

endmodule

// File: rtl/asf_logic.sv
module asf_logic #(
  parameter int BW = 8,
  localparam int DW = 4 * BW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] mask,
  input  logic [1:0]    fn,
  output logic [DW-1:0] y
);
  import asf_pkg::*;

  logic [DW-1:0] raw;

  always_comb begin
    unique case (lfn_e'(fn))
      LF_AND:  raw = a & b;
      LF_OR:   raw = a | b;
      LF_XOR:  raw = a ^ b;
      default: raw = a;
    endcase
    y = raw & mask;
  end

endmodule

// File: rtl/asf_flags.sv
module asf_flags #(
  parameter int BW = 8,
  localparam int DW = 4 * BW
) (
  input  logic [DW-1:0]   res,
  input  logic [1:0]      idx,
  input  logic            logic_en,
  input  logic            cf_a,
  input  logic            af_a,
  input  logic            of_a,
  input  logic            af_prev,
  output asf_pkg::flags_t nxt
);
  logic [2:0] msb_v;

  for (genvar g = 0; g < 3; g++) begin : g_msb
    assign msb_v[g] = res[(BW << g) - 1];
  end

  always_comb begin
    nxt.pf_f = ~^res[BW-1:0];
    nxt.zf_f = (res == '0);
    nxt.sf_f = msb_v[idx];
    nxt.cf_f = logic_en ? 1'b0 : cf_a;
    nxt.of_f = logic_en ? 1'b0 : of_a;
    nxt.af_f = logic_en ? af_prev : af_a;
  end

endmodule

// File: rtl/asf_flag_gen.sv
module asf_flag_gen #(
  parameter int BW = 8,
  localparam int DW = 4 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          carry_in,
  input  logic          sub_sel,
  input  logic [1:0]    size_sel,
  input  logic          logic_en,
  input  logic [1:0]    logic_fn,
  output logic [DW-1:0] result,
  output logic          cf,
  output logic          pf,
  output logic          af,
  output logic          zf,
  output logic          sf,
  output logic          of,
  output logic [asf_pkg::ASF_WORD_W-1:0] status_word
);
  import asf_pkg::*;

  logic [1:0]    idx;
  logic [DW-1:0] mask;
  logic [DW-1:0] sum_w;
  logic [DW-1:0] log_w;
  logic [DW-1:0] res_d;
  logic          cf_a, af_a, of_a;
  flags_t        flg_d;
  flags_t        flg_q;
  logic [DW-1:0] res_q;

  assign idx = size_idx(size_sel);

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i < (BW << idx));
  end

  asf_adder #(.BW(BW)) u_add (
    .a(op_a), .b(op_b), .mask(mask), .idx(idx), .cin(carry_in),
    .sub(sub_sel), .sum(sum_w), .cf_o(cf_a), .af_o(af_a), .of_o(of_a)
  );

  asf_logic #(.BW(BW)) u_log (
    .a(op_a), .b(op_b), .mask(mask), .fn(logic_fn), .y(log_w)
  );

  assign res_d = logic_en ? log_w : sum_w;

  asf_flags #(.BW(BW)) u_flg (
    .res(res_d), .idx(idx), .logic_en(logic_en), .cf_a(cf_a),
    .af_a(af_a), .of_a(of_a), .af_prev(flg_q.af_f), .nxt(flg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '{of_f: 1'b0, sf_f: 1'b0, zf_f: 1'b1, af_f: 1'b0,
                 pf_f: 1'b1, cf_f: 1'b0};
    end else if (upd_en) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result = res_q;
  assign cf = flg_q.cf_f;
  assign pf = flg_q.pf_f;
  assign af = flg_q.af_f;
  assign zf = flg_q.zf_f;
  assign sf = flg_q.sf_f;
  assign of = flg_q.of_f;

  always_comb begin
    status_word         = '0;
    status_word[POS_CF] = flg_q.cf_f;
    status_word[POS_PF] = flg_q.pf_f;
    status_word[POS_AF] = flg_q.af_f;
    status_word[POS_ZF] = flg_q.zf_f;
    status_word[POS_SF] = flg_q.sf_f;
    status_word[POS_OF] = flg_q.of_f;
  end

endmodule

// File: rtl/asf_chk.sv
module asf_chk #(
  parameter int BW = 8,
  localparam int DW = 4 * BW
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_en,
  input logic          logic_en,
  input logic [1:0]    size_sel,
  input logic [DW-1:0] result,
  input logic          cf,
  input logic          pf,
  input logic          af,
  input logic          zf,
  input logic          sf,
  input logic          of,
  input logic [15:0]   status_word
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> ($stable(result) && $stable(status_word))); // R9

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (upd_en && logic_en) |=> (!cf && !of)); // R7

  AST_LOGIC_AF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (upd_en && logic_en) |=> (af == $past(af))); // R7

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    zf == (result == '0)); // R4

  AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    pf == ~^result[BW-1:0]); // R2

  AST_SIGN_AT_WIDTH: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (sf == (($past(size_sel) == 2'b00) ? result[BW-1] :
                       ($past(size_sel) == 2'b01) ? result[2*BW-1] :
                                                    result[DW-1]))); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (upd_en && size_sel == 2'b00) |=> (result[DW-1:BW] == '0)); // R10

endmodule

bind asf_flag_gen asf_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .upd_en(upd_en), .logic_en(logic_en),
  .size_sel(size_sel), .result(result), .cf(cf), .pf(pf), .af(af),
  .zf(zf), .sf(sf), .of(of), .status_word(status_word)
);

// File: tb/tb_asf_flag_gen.sv
`timescale 1ns/1ps
module tb_asf_flag_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0, sub_sel = 1'b0, logic_en = 1'b0;
  logic [1:0]  size_sel = 2'b00, logic_fn = 2'b00;
  logic [31:0] result;
  logic        cf, pf, af, zf, sf, of;
  logic [15:0] status_word;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] e_res;
  logic        e_cf, e_pf, e_af, e_zf, e_sf, e_of;
  logic [31:0] seed = 32'h1234_5678;

  asf_flag_gen dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sub_sel(sub_sel), .size_sel(size_sel),
    .logic_en(logic_en), .logic_fn(logic_fn), .result(result),
    .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of),
    .status_word(status_word)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rnd(inout logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h c=%b sub=%b sz=%b log=%b fn=%b)",
               tag, act, exp, op_a, op_b, carry_in, sub_sel, size_sel, logic_en, logic_fn);
    end
  endtask

  task automatic compare_all();
    logic [15:0] w;
    w = '0;
    w[0] = e_cf; w[2] = e_pf; w[4] = e_af; w[6] = e_zf; w[7] = e_sf; w[11] = e_of;
    chk("R12/R10 result", result, e_res);
    chk("R1 cf", 32'(cf), 32'(e_cf));
    chk("R2 pf", 32'(pf), 32'(e_pf));
    chk("R3 af", 32'(af), 32'(e_af));
    chk("R4 zf", 32'(zf), 32'(e_zf));
    chk("R5 sf", 32'(sf), 32'(e_sf));
    chk("R6 of", 32'(of), 32'(e_of));
    chk("R8 status_word", 32'(w), 32'(status_word));
  endtask

  // Drive at a falling edge, predict, compare at the next falling edge.
  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic c,
                    input logic s, input logic [1:0] sz, input logic le,
                    input logic [1:0] fn, input logic en);
    int w;
    logic [63:0] msk, am, bm, full;
    logic [31:0] r;
    logic sa, sb, sr;
    op_a = a; op_b = b; carry_in = c; sub_sel = s; size_sel = sz;
    logic_en = le; logic_fn = fn; upd_en = en;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    msk = (64'd1 << w) - 64'd1;
    am = {32'd0, a} & msk;
    bm = {32'd0, b} & msk;
    if (en) begin
      if (le) begin
        case (fn)
          2'b00: r = a & b;
          2'b01: r = a | b;
          2'b10: r = a ^ b;
          default: r = a;
        endcase
        r = r & msk[31:0];
        e_cf = 1'b0; e_of = 1'b0;
      end else begin
        sa = am[w-1]; sb = bm[w-1];
        if (!s) begin
          full = am + bm + 64'(c);
          r = full[31:0] & msk[31:0];
          e_cf = full[w];
          e_af = ((am & 64'hF) + (bm & 64'hF) + 64'(c)) > 64'hF;
          sr = r[w-1];
          e_of = (sa == sb) && (sr != sa);
        end else begin
          full = am - bm - 64'(c);
          r = full[31:0] & msk[31:0];
          e_cf = am < (bm + 64'(c));
          e_af = (am & 64'hF) < ((bm & 64'hF) + 64'(c));
          sr = r[w-1];
          e_of = (sa != sb) && (sr != sa);
        end
      end
      e_res = r;
      e_pf = ~^r[7:0];
      e_zf = (r == 32'd0);
      e_sf = r[w-1];
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    e_res = '0; e_cf = 0; e_pf = 1; e_af = 0; e_zf = 1; e_sf = 0; e_of = 0;
    compare_all();

    // 8-bit sweep with junk above the active width (R1-R6, R10)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5)
        for (int k = 0; k < 4; k++)
          op(32'hA5C3_0000 | 32'(a), 32'h5A3C_0000 | 32'(b), k[0], k[1],
             2'b00, 1'b0, 2'b00, 1'b1);

    // 16/32-bit and spare size corners (R1, R5, R6, R10)
    for (int sz = 1; sz < 4; sz++) begin
      op(32'hFFFF_7FFF, 32'h0000_0001, 1'b0, 1'b0, 2'(sz), 1'b0, 2'b00, 1'b1);
      op(32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'(sz), 1'b0, 2'b00, 1'b1);
      op(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 2'(sz), 1'b0, 2'b00, 1'b1);
      op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'(sz), 1'b0, 2'b00, 1'b1);
      op(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'(sz), 1'b0, 2'b00, 1'b1);
      op(32'h8000_8000, 32'h0000_0001, 1'b0, 1'b1, 2'(sz), 1'b0, 2'b00, 1'b1);
      op(32'h0000_0010, 32'h0000_0000, 1'b1, 1'b1, 2'(sz), 1'b0, 2'b00, 1'b1);
      for (int i = 0; i < 400; i++) begin
        x = rnd(seed); y = rnd(seed);
        op(x, y, x[3], y[7], 2'(sz), 1'b0, 2'b00, 1'b1);
      end
    end

    // R7: logical mode with af previously set, then cleared
    for (int pre = 0; pre < 2; pre++)
      for (int i = 0; i < 200; i++) begin
        if (pre == 0) op(32'h0F, 32'h01, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1);
        else          op(32'h10, 32'h00, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1);
        x = rnd(seed); y = rnd(seed);
        op(x, y, 1'b1, 1'b0, 2'(i % 3), 1'b1, 2'(i % 4), 1'b1);
      end

    // R9: enable low holds everything while inputs change
    op(32'h0000_0080, 32'h0000_0080, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1);
    for (int i = 0; i < 200; i++) begin
      x = rnd(seed); y = rnd(seed);
      op(x, y, x[0], x[1], x[3:2], x[4], x[6:5], 1'b0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule